// File: doc/BRIEF.md
# Two-Level Temperature Alert Controller

This block watches a stream of temperature samples, expressed in kelvin, and keeps a three-region thermal policy: normal, warning and critical. It has a single pair of comparators, one for "over" and one for "under". The thresholds these comparators use are re-pointed every time the region changes. In the normal region only the over comparator is armed, and it watches the warning limit. In the warning region the over comparator moves to the critical limit and the under comparator is armed at the warning limit. This gives a warning band with hysteresis, plus an escape to the critical region.

Samples arrive with a valid strobe. The block accepts every strobed sample and applies no back-pressure, so there is no ready signal. The outputs are as follows:
- the current region;
- a cooling request, high in both the warning and the critical region;
- a shutdown request, high in the critical region;
- a one-cycle event pulse, carrying the code of the newly entered region.

The critical region holds until software asks to leave it. That request takes effect only when the same cycle carries a valid sample below the warning limit. A limit pair that makes no sense (warning not below critical) raises a configuration error. It also forces the block back to normal, with all alerts disarmed.

Top module: `thermal_band_ctrl`

## Requirements
- R1: After reset the region is normal (code 0). The cooling request, shutdown request and event pulse are all low.
- R2: In the normal region, a valid sample strictly greater than the warning limit moves the block to the warning region (code 1). A sample equal to the limit leaves the region unchanged.
- R3: In the warning region, a valid sample strictly greater than the critical limit moves the block to the critical region (code 2). A sample equal to the critical limit leaves the region unchanged.
- R4: In the warning region, a valid sample strictly less than the warning limit returns the block to normal. A sample equal to the warning limit keeps the block in warning.
- R5: The normal region never moves straight to critical. A valid sample above the critical limit taken in normal leads to the warning region only.
- R6: The critical region holds. It is left for normal only in a cycle where all three of these are true:
  - the clear input is high;
  - a valid sample is present;
  - that sample is strictly less than the warning limit.
  
  A clear without a valid sample, or with a sample at or above the warning limit, has no effect.
- R7: Samples are compared only in cycles where the valid strobe is high. An unstrobed value has no effect on the region.
- R8: Every region change raises the event pulse for exactly one cycle, with the event code equal to the new region. Codes are 0 for normal, 1 for warning and 2 for critical. Both the event and the new region become visible after the clock edge that took the deciding sample.
- R9: The cooling request is high exactly while the region is warning or critical. The shutdown request is high exactly while the region is critical.
- R10: The configuration error output is high whenever the warning limit is not below the critical limit. While it is high, samples are ignored and the region is forced to normal at the next edge. If this changes the region, an event is raised as for any other change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Strobe marking a new temperature sample |
| temp_k | input | 16 | Temperature sample in kelvin, unsigned |
| warn_lim | input | 16 | Warning limit in kelvin |
| crit_lim | input | 16 | Critical limit in kelvin |
| clear_crit | input | 1 | Request to leave the critical region |
| region | output | 2 | Current region code (0 normal, 1 warning, 2 critical) |
| cool_req | output | 1 | Cooling request |
| shutdown_req | output | 1 | Shutdown or emergency request |
| evt_pulse | output | 1 | One-cycle pulse on each region change |
| evt_region | output | 2 | Region code carried by the event pulse |
| cfg_err | output | 1 | Limits are inconsistent (warning not below critical) |

## Verification
Two pairs of functions can coincide in one cycle, and each pair is provoked deliberately.

The first pair is the clear request and the under comparison while the block is critical. The clear is driven three ways:
- with no strobe;
- with a strobed sample exactly at the warning limit;
- with a strobed sample one kelvin below it.

Only the last of these may return the region to normal.

The second pair is a bad limit configuration landing in the same cycle as a strobed sample that would otherwise cross a threshold. This is tried both from normal and from warning. The scoreboard expects the forced return to normal, with an event only when the region actually changed, and expects the crossing to be ignored.

// File: rtl/thermal_band_pkg.sv
package thermal_band_pkg;
  typedef enum logic [1:0] {
    RGN_NORMAL = 2'd0,
    RGN_WARN   = 2'd1,
    RGN_CRIT   = 2'd2
  } region_e;
endpackage

// File: rtl/thr_select.sv
// Points the over/under comparators at the limits that matter in the current region.
module thr_select
  import thermal_band_pkg::*;
#(
  parameter int TW = 16
) (
  input  region_e         rgn,
  input  logic [TW-1:0]   warn_lim,
  input  logic [TW-1:0]   crit_lim,
  input  logic            cfg_bad,
  output logic [TW-1:0]   over_thr,
  output logic            over_arm,
  output logic [TW-1:0]   under_thr,
  output logic            under_arm
);
  always_comb begin
    over_thr  = warn_lim;
    over_arm  = 1'b0;
    under_thr = warn_lim;
    under_arm = 1'b0;
    if (!cfg_bad) begin
      unique case (rgn)
        RGN_NORMAL: begin
          over_thr = warn_lim;
          over_arm = 1'b1;
        end
        RGN_WARN: begin
          over_thr  = crit_lim;
          over_arm  = 1'b1;
          under_thr = warn_lim;
          under_arm = 1'b1;
        end
        RGN_CRIT: begin
          // The under compare qualifies the clear request.
          under_thr = warn_lim;
          under_arm = 1'b1;
        end
        default: begin
          over_arm  = 1'b0;
          under_arm = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/thr_compare.sv
// One strict over comparator and one strict under comparator, gated by the sample strobe.
module thr_compare #(
  parameter int TW = 16
) (
  input  logic          temp_valid,
  input  logic [TW-1:0] temp_k,
  input  logic [TW-1:0] over_thr,
  input  logic          over_arm,
  input  logic [TW-1:0] under_thr,
  input  logic          under_arm,
  output logic          over_hit,
  output logic          under_hit
);
  assign over_hit  = temp_valid && over_arm  && (temp_k > over_thr);
  assign under_hit = temp_valid && under_arm && (temp_k < under_thr);
endmodule

// File: rtl/band_fsm.sv
// Region state machine with a registered event pulse.
module band_fsm
  import thermal_band_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    over_hit,
  input  logic    under_hit,
  input  logic    clear_req,
  input  logic    cfg_bad,
  output region_e rgn,
  output logic    evt,
  output region_e evt_rgn
);
  region_e nxt;

  always_comb begin
    nxt = rgn;
    if (cfg_bad) begin
      nxt = RGN_NORMAL;
    end else begin
      unique case (rgn)
        RGN_NORMAL: if (over_hit) nxt = RGN_WARN;
        RGN_WARN: begin
          if (over_hit)       nxt = RGN_CRIT;
          else if (under_hit) nxt = RGN_NORMAL;
        end
        RGN_CRIT: if (clear_req && under_hit) nxt = RGN_NORMAL;
        default: nxt = RGN_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgn     <= RGN_NORMAL;
      evt     <= 1'b0;
      evt_rgn <= RGN_NORMAL;
    end else begin
      rgn     <= nxt;
      evt     <= (nxt != rgn);
      evt_rgn <= nxt;
    end
  end
endmodule

// File: rtl/thermal_band_ctrl.sv
module thermal_band_ctrl
  import thermal_band_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          temp_valid,
  input  logic [TW-1:0] temp_k,
  input  logic [TW-1:0] warn_lim,
  input  logic [TW-1:0] crit_lim,
  input  logic          clear_crit,
  output logic [1:0]    region,
  output logic          cool_req,
  output logic          shutdown_req,
  output logic          evt_pulse,
  output logic [1:0]    evt_region,
  output logic          cfg_err
);
  logic          cfg_bad;
  logic [TW-1:0] over_thr;
  logic [TW-1:0] under_thr;
  logic          over_arm;
  logic          under_arm;
  logic          over_hit;
  logic          under_hit;
  region_e       rgn;
  region_e       evt_rgn;

  assign cfg_bad = (warn_lim >= crit_lim);

  thr_select #(.TW(TW)) u_sel (
    .rgn       (rgn),
    .warn_lim  (warn_lim),
    .crit_lim  (crit_lim),
    .cfg_bad   (cfg_bad),
    .over_thr  (over_thr),
    .over_arm  (over_arm),
    .under_thr (under_thr),
    .under_arm (under_arm)
  );

  thr_compare #(.TW(TW)) u_cmp (
    .temp_valid (temp_valid),
    .temp_k     (temp_k),
    .over_thr   (over_thr),
    .over_arm   (over_arm),
    .under_thr  (under_thr),
    .under_arm  (under_arm),
    .over_hit   (over_hit),
    .under_hit  (under_hit)
  );

  band_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .over_hit  (over_hit),
    .under_hit (under_hit),
    .clear_req (clear_crit),
    .cfg_bad   (cfg_bad),
    .rgn       (rgn),
    .evt       (evt_pulse),
    .evt_rgn   (evt_rgn)
  );

  assign region       = rgn;
  assign evt_region   = evt_rgn;
  assign cool_req     = (rgn != RGN_NORMAL);
  assign shutdown_req = (rgn == RGN_CRIT);
  assign cfg_err      = cfg_bad;
endmodule

// File: rtl/thermal_band_chk.sv
module thermal_band_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          temp_valid,
  input logic [TW-1:0] temp_k,
  input logic [TW-1:0] warn_lim,
  input logic [TW-1:0] crit_lim,
  input logic          clear_crit,
  input logic [1:0]    region,
  input logic          cool_req,
  input logic          shutdown_req,
  input logic          evt_pulse,
  input logic [1:0]    evt_region,
  input logic          cfg_err
);
  assert_no_skip_to_crit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd0) |=> (region != 2'd2));

  assert_crit_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd2 && !clear_crit && !cfg_err) |=> (region == 2'd2));

  assert_no_move_without_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_valid && !cfg_err) |=> $stable(region));

  assert_evt_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (region != $past(region)) |-> (evt_pulse && evt_region == region));

  assert_evt_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (region != $past(region)));

  assert_outputs_follow_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cool_req == (region != 2'd0)) && (shutdown_req == (region == 2'd2)));

  assert_cfg_forces_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (region == 2'd0));
endmodule

bind thermal_band_ctrl thermal_band_chk #(.TW(TW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .temp_valid   (temp_valid),
  .temp_k       (temp_k),
  .warn_lim     (warn_lim),
  .crit_lim     (crit_lim),
  .clear_crit   (clear_crit),
  .region       (region),
  .cool_req     (cool_req),
  .shutdown_req (shutdown_req),
  .evt_pulse    (evt_pulse),
  .evt_region   (evt_region),
  .cfg_err      (cfg_err)
);

// File: tb/thermal_band_ctrl_tb.sv
module thermal_band_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        temp_valid = 1'b0;
  logic [15:0] temp_k = '0;
  logic [15:0] warn_lim = 16'd300;
  logic [15:0] crit_lim = 16'd350;
  logic        clear_crit = 1'b0;
  logic [1:0]  region;
  logic        cool_req;
  logic        shutdown_req;
  logic        evt_pulse;
  logic [1:0]  evt_region;
  logic        cfg_err;

  typedef struct packed {
    logic [1:0] rgn;
    logic       evt;
    logic [1:0] ergn;
    logic       cool;
    logic       shut;
    logic       cerr;
  } exp_t;

  exp_t        expq[$];
  string       tagq[$];
  int          n_tests = 0;
  int          n_fail = 0;
  logic [1:0]  m_rgn = 2'd0;
  logic [1:0]  m_last_ergn = 2'd0;
  bit          done = 0;

  always #4 clk = ~clk;

  thermal_band_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .temp_valid (temp_valid), .temp_k (temp_k),
    .warn_lim (warn_lim), .crit_lim (crit_lim), .clear_crit (clear_crit),
    .region (region), .cool_req (cool_req), .shutdown_req (shutdown_req),
    .evt_pulse (evt_pulse), .evt_region (evt_region), .cfg_err (cfg_err)
  );

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input bit v, input int t, input int w, input int c,
                      input bit clr, input string tag);
    logic [1:0] nx;
    bit         bad;
    exp_t       e;
    @(negedge clk);
    temp_valid = v; temp_k = 16'(t); warn_lim = 16'(w); crit_lim = 16'(c);
    clear_crit = clr;
    bad = (w >= c);
    nx = m_rgn;
    if (bad) nx = 2'd0;
    else if (m_rgn == 2'd0) begin
      if (v && t > w) nx = 2'd1;
    end else if (m_rgn == 2'd1) begin
      if (v && t > c)      nx = 2'd2;
      else if (v && t < w) nx = 2'd0;
    end else begin
      if (clr && v && t < w) nx = 2'd0;
    end
    e.rgn  = nx;
    e.evt  = (nx != m_rgn);
    e.ergn = nx;
    e.cool = (nx != 2'd0);
    e.shut = (nx == 2'd2);
    e.cerr = bad;
    m_rgn = nx;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // Monitor: samples after each active edge and compares with the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && expq.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string tg;
        e  = expq.pop_front();
        tg = tagq.pop_front();
        a.rgn = region; a.evt = evt_pulse; a.cool = cool_req;
        a.shut = shutdown_req; a.cerr = cfg_err;
        a.ergn = evt_pulse ? evt_region : e.ergn;
        if (!e.evt) e.ergn = a.ergn;
        n_tests++;
        if (a != e) begin
          n_fail++;
          $display("FAIL %s: rgn/evt/ergn/cool/shut/cerr actual %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
                   tg, a.rgn, a.evt, a.ergn, a.cool, a.shut, a.cerr,
                   e.rgn, e.evt, e.ergn, e.cool, e.shut, e.cerr);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (region !== 2'd0 || cool_req !== 1'b0 || shutdown_req !== 1'b0 || evt_pulse !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual rgn %0d cool %0d shut %0d evt %0d expected 0 0 0 0",
               region, cool_req, shutdown_req, evt_pulse);
    end
    rst_n = 1'b1;
    step(1, 290, 300, 350, 0, "R2 below warn");
    step(1, 300, 300, 350, 0, "R2 equal warn");
    step(0, 400, 300, 350, 0, "R7 unstrobed");
    step(1, 301, 300, 350, 0, "R2 R8 R9 enter warn");
    step(1, 350, 300, 350, 0, "R3 equal crit");
    step(1, 300, 300, 350, 0, "R4 equal warn");
    step(1, 299, 300, 350, 0, "R4 back to normal");
    step(1, 400, 300, 350, 0, "R5 no skip");
    step(1, 351, 300, 350, 0, "R3 R8 R9 enter crit");
    step(1, 200, 300, 350, 0, "R6 no clear");
    step(0, 200, 300, 350, 1, "R6 clear unstrobed");
    step(1, 300, 300, 350, 1, "R6 clear at warn");
    step(1, 299, 300, 350, 1, "R6 clear ok");
    step(1, 400, 350, 350, 0, "R10 bad cfg normal");
    step(1, 400, 360, 350, 0, "R10 inverted cfg");
    step(1, 320, 300, 350, 0, "R10 cfg restored warn");
    step(1, 400, 350, 340, 0, "R10 bad cfg from warn");
    step(1, 320, 300, 350, 0, "R8 rewarn");
    step(1, 360, 300, 350, 0, "R3 crit again");
    step(1, 100, 350, 340, 0, "R10 bad cfg from crit");
    step(0, 0, 300, 350, 0, "R7 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule